// File: doc/BRIEF.md
# Network Port Select and Frame Reject Logic

This block decides which of two network attachments is live, the twisted-pair port or the AUI port, and drives the active-high disable line of the external transceiver. The decision comes either from a dual-use select pin or from a software port bit, depending on a configuration bit. When the external address detect mode is on, the select pin takes a second role. It becomes an active-low reject input, and the port always comes from software.

A frame's reject verdict combines the internal address filter result with the external reject input. The verdict is registered on a frame-end strobe and held until the next frame begins. The same mode reroutes three of the four active-low LED outputs to frame delimiter, receive data and receive clock. A sleep input parks all outputs in their reset condition.

Top module: `netPortSel`

## Requirements
- R1: With `pinCtrlEn`=1 and `extAddrMode`=0, `selPin`=1 makes `tpActive`=1, `auiActive`=0, and `selPin`=0 makes `tpActive`=0, `auiActive`=1. These outputs are combinational.
- R2: With `pinCtrlEn`=0 and `extAddrMode`=0, the port follows `swPortTp` (1 selects twisted pair) and `selPin` has no effect. While awake, exactly one of `tpActive` and `auiActive` is 1.
- R3: With `extAddrMode`=1, the port follows `swPortTp` whatever the values of `pinCtrlEn` and `selPin`.
- R4: `xcvrDisable` is 1 when twisted pair is active or `asleep`=1, and 0 when AUI is active and `asleep`=0.
- R5: With `asleep`=1, `tpActive`=`auiActive`=0 and `ledN` is all ones. One clock edge later `frameReject` is 0, and frame strobes are ignored while `asleep`=1.
- R6: A `frameEnd` pulse loads `frameReject` with `filterReject` OR (`extAddrMode` AND NOT `selPin`). The new value is visible after that clock edge.
- R7: With `extAddrMode`=0, `selPin` does not contribute to the captured verdict.
- R8: `frameReject` holds between strobes. A `frameStart` pulse alone clears it after the edge. When `frameStart` and `frameEnd` coincide, the capture wins.
- R9: `ledN[0]` = NOT `linkUp` while awake. For i in 1..3, `ledN[i]` = NOT `swLedStat[i-1]` when `extAddrMode`=0. When `extAddrMode`=1, `ledN[1]`, `ledN[2]` and `ledN[3]` are NOT `sfbd`, NOT `rxData` and NOT `rxClk` respectively.
- R10: While `rstN`=0, `frameReject` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selPin | input | 1 | Dual-use pin: port select, or active-low external reject |
| pinCtrlEn | input | 1 | 1: port comes from the pin |
| swPortTp | input | 1 | Software port choice, 1 = twisted pair |
| extAddrMode | input | 1 | External address detect mode enable |
| asleep | input | 1 | Sleep status |
| filterReject | input | 1 | Internal address filter reject result |
| frameStart | input | 1 | Start-of-frame strobe |
| frameEnd | input | 1 | End-of-frame strobe |
| linkUp | input | 1 | Twisted-pair link status |
| sfbd | input | 1 | Start-frame / byte delimiter status |
| rxData | input | 1 | Receive data |
| rxClk | input | 1 | Receive clock |
| swLedStat | input | 3 | Software-selected LED status bits |
| tpActive | output | 1 | Twisted-pair port active |
| auiActive | output | 1 | AUI port active |
| xcvrDisable | output | 1 | Transceiver disable |
| frameReject | output | 1 | Registered frame reject verdict |
| ledN | output | 4 | Active-low LED drives |

## Verification
The assertions assume that `filterReject`, `selPin` and `extAddrMode` are settled in the cycle that carries `frameEnd`. They also assume the strobes are single-cycle pulses sampled on the rising edge. The stimulus changes every input on the falling edge and raises a strobe for exactly one cycle, so each strobe meets one rising edge. Sleep is entered and left between frames, and the bench also places one strobe inside a sleep interval to show it is ignored.

// File: rtl/netsel_pkg.sv
package netsel_pkg;
  typedef struct packed {
    logic capture;
    logic clear;
    logic extReject;
    logic sleepHold;
  } selStrobe_t;
endpackage

// File: rtl/netsel_ctrl.sv
module netsel_ctrl
  import netsel_pkg::*;
(
  input  logic       selPin,
  input  logic       pinCtrlEn,
  input  logic       swPortTp,
  input  logic       extAddrMode,
  input  logic       asleep,
  input  logic       frameStart,
  input  logic       frameEnd,
  output logic       tpActive,
  output logic       auiActive,
  output selStrobe_t strb
);
  logic pinAsPort;
  logic portTp;

  // the pin selects the port only when configured and not reused as reject
  assign pinAsPort = pinCtrlEn & ~extAddrMode;
  assign portTp    = pinAsPort ? selPin : swPortTp;
  assign tpActive  = ~asleep & portTp;
  assign auiActive = ~asleep & ~portTp;

  always_comb begin
    strb.sleepHold = asleep;
    strb.extReject = extAddrMode & ~selPin;
    strb.capture   = frameEnd & ~asleep;
    strb.clear     = frameStart & ~frameEnd & ~asleep;
  end
endmodule

// File: rtl/netsel_dp.sv
module netsel_dp
  import netsel_pkg::*;
#(
  parameter int ALT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  selStrobe_t       strb,
  input  logic             tpActive,
  input  logic             auiActive,
  input  logic             extAddrMode,
  input  logic             filterReject,
  input  logic             linkUp,
  input  logic [ALT_W-1:0] altSig,
  input  logic [ALT_W-1:0] swLedStat,
  output logic             xcvrDisable,
  output logic             frameReject,
  output logic [ALT_W:0]   ledN
);
  localparam int LED_N = ALT_W + 1;

  logic rejQ;

  always_ff @(posedge clk) begin
    if (!rstN)              rejQ <= 1'b0;
    else if (strb.sleepHold) rejQ <= 1'b0;
    else if (strb.capture)  rejQ <= filterReject | strb.extReject;
    else if (strb.clear)    rejQ <= 1'b0;
  end

  assign frameReject = rejQ;
  assign xcvrDisable = strb.sleepHold | tpActive;
  assign ledN[0]     = strb.sleepHold | ~linkUp;

  for (genvar i = 1; i < LED_N; i++) begin : g_led
    assign ledN[i] = strb.sleepHold |
                     ~(extAddrMode ? altSig[i-1] : swLedStat[i-1]);
  end

  a_r2_one_port: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sleepHold |-> $countones({tpActive, auiActive}) == 1);
  a_r4_aui_enables: assert property (@(posedge clk) disable iff (!rstN)
    (auiActive && !strb.sleepHold) |-> !xcvrDisable);
  a_r5_sleep_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.sleepHold |=> !frameReject);
  a_r6_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> frameReject == $past(filterReject | strb.extReject));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !strb.clear && !strb.sleepHold) |=> $stable(frameReject));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !frameReject);
endmodule

// File: rtl/netPortSel.sv
module netPortSel
  import netsel_pkg::*;
#(
  parameter int ALT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selPin,
  input  logic             pinCtrlEn,
  input  logic             swPortTp,
  input  logic             extAddrMode,
  input  logic             asleep,
  input  logic             filterReject,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             linkUp,
  input  logic             sfbd,
  input  logic             rxData,
  input  logic             rxClk,
  input  logic [ALT_W-1:0] swLedStat,
  output logic             tpActive,
  output logic             auiActive,
  output logic             xcvrDisable,
  output logic             frameReject,
  output logic [ALT_W:0]   ledN
);
  selStrobe_t      strb;
  logic [ALT_W-1:0] altSig;

  always_comb begin
    altSig    = '0;
    altSig[0] = sfbd;
    if (ALT_W > 1) altSig[1] = rxData;
    if (ALT_W > 2) altSig[2] = rxClk;
  end

  netsel_ctrl u_ctrl (
    .selPin(selPin), .pinCtrlEn(pinCtrlEn), .swPortTp(swPortTp),
    .extAddrMode(extAddrMode), .asleep(asleep), .frameStart(frameStart),
    .frameEnd(frameEnd), .tpActive(tpActive), .auiActive(auiActive),
    .strb(strb)
  );

  netsel_dp #(.ALT_W(ALT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tpActive(tpActive),
    .auiActive(auiActive), .extAddrMode(extAddrMode),
    .filterReject(filterReject), .linkUp(linkUp), .altSig(altSig),
    .swLedStat(swLedStat), .xcvrDisable(xcvrDisable),
    .frameReject(frameReject), .ledN(ledN)
  );
endmodule

// File: tb/test_netPortSel.sv
module test_netPortSel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic selPin = 1'b1, pinCtrlEn = 1'b0, swPortTp = 1'b0, extAddrMode = 1'b0;
  logic asleep = 1'b0, filterReject = 1'b0, frameStart = 1'b0, frameEnd = 1'b0;
  logic linkUp = 1'b0, sfbd = 1'b0, rxData = 1'b0, rxClk = 1'b0;
  logic [2:0] swLedStat = 3'b000;
  logic tpActive, auiActive, xcvrDisable, frameReject;
  logic [3:0] ledN;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  netPortSel i_netPortSel (
    .clk(clk), .rstN(rstN), .selPin(selPin), .pinCtrlEn(pinCtrlEn),
    .swPortTp(swPortTp), .extAddrMode(extAddrMode), .asleep(asleep),
    .filterReject(filterReject), .frameStart(frameStart), .frameEnd(frameEnd),
    .linkUp(linkUp), .sfbd(sfbd), .rxData(rxData), .rxClk(rxClk),
    .swLedStat(swLedStat), .tpActive(tpActive), .auiActive(auiActive),
    .xcvrDisable(xcvrDisable), .frameReject(frameReject), .ledN(ledN)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one strobe cycle: drive on falling edge, check after the following falling edge
  task automatic pulse(logic st, logic en);
    @(negedge clk); frameStart = st; frameEnd = en;
    @(negedge clk); frameStart = 0; frameEnd = 0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset", {7'b0, frameReject}, 8'h0);
    rstN = 1'b1;
    @(negedge clk);

    // exhaustive combinational sweep: port choice, transceiver, LEDs
    for (int v = 0; v < 4096; v++) begin
      logic expTp;
      logic [3:0] expLed;
      {selPin, pinCtrlEn, swPortTp, extAddrMode, asleep, linkUp,
       sfbd, rxData, rxClk, swLedStat} = 12'(v);
      #1;
      expTp = (pinCtrlEn && !extAddrMode) ? selPin : swPortTp;
      if (asleep) begin
        chk("R5 ports off", {6'b0, tpActive, auiActive}, 8'h0);
        chk("R5 leds off", {4'b0, ledN}, 8'h0f);
        chk("R4 sleep xcvr", {7'b0, xcvrDisable}, 8'h1);
      end else begin
        if (pinCtrlEn && !extAddrMode)
          chk("R1 pin select", {6'b0, tpActive, auiActive}, {6'b0, expTp, !expTp});
        else if (!extAddrMode)
          chk("R2 sw select", {6'b0, tpActive, auiActive}, {6'b0, expTp, !expTp});
        else
          chk("R3 ext mode sw select", {6'b0, tpActive, auiActive}, {6'b0, expTp, !expTp});
        chk("R4 xcvr", {7'b0, xcvrDisable}, {7'b0, expTp});
        expLed[0] = !linkUp;
        expLed[3:1] = extAddrMode ? ~{rxClk, rxData, sfbd} : ~swLedStat;
        chk("R9 leds", {4'b0, ledN}, {4'b0, expLed});
      end
      #1;
    end
    @(negedge clk);
    asleep = 0;

    // reject capture over all filter / mode / pin combinations
    for (int v = 0; v < 8; v++) begin
      logic expRej;
      {filterReject, extAddrMode, selPin} = 3'(v);
      expRej = filterReject | (extAddrMode & !selPin);
      pulse(1'b0, 1'b1);
      if (!extAddrMode)
        chk("R7 pin ignored", {7'b0, frameReject}, {7'b0, filterReject});
      else
        chk("R6 capture", {7'b0, frameReject}, {7'b0, expRej});
      // inputs change without strobes: verdict held
      filterReject = !filterReject; selPin = !selPin;
      @(negedge clk); @(negedge clk);
      chk("R8 hold", {7'b0, frameReject}, {7'b0, expRej});
      pulse(1'b1, 1'b0);
      chk("R8 clear on start", {7'b0, frameReject}, 8'h0);
    end

    // coincident strobes: capture wins
    filterReject = 1; extAddrMode = 0;
    pulse(1'b1, 1'b1);
    chk("R8 end wins", {7'b0, frameReject}, 8'h1);

    // sleep clears the verdict and ignores strobes
    @(negedge clk); asleep = 1;
    @(negedge clk);
    chk("R5 sleep clears", {7'b0, frameReject}, 8'h0);
    pulse(1'b0, 1'b1);
    chk("R5 strobe ignored asleep", {7'b0, frameReject}, 8'h0);
    asleep = 0;
    @(negedge clk);
    chk("R5 wake no verdict", {7'b0, frameReject}, 8'h0);

    // reset clears a set verdict
    pulse(1'b0, 1'b1);
    chk("R6 capture before reset", {7'b0, frameReject}, 8'h1);
    rstN = 0;
    @(negedge clk);
    chk("R10 reset clears", {7'b0, frameReject}, 8'h0);
    rstN = 1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule